// File: doc/BRIEF.md
# Transmit Descriptor List Walker

This block works through a list of transmit descriptors in shared memory for an Ethernet-style transmit path. Each descriptor is four 32-bit words. Word 0 carries an ownership flag together with control and status bits. Word 1 gives two buffer byte counts. Word 2 points at the first buffer. Word 3 points either at a second buffer or at the next descriptor.

The walker reads a descriptor and checks that the DMA side owns it. It then issues one word read per four bytes of each non-empty buffer and forwards every returned word to the transmit path. A frame may span several descriptors, from the one marked first segment to the one marked last segment. The frame's control bits come from the first descriptor only.

When an intermediate descriptor has been consumed, the walker hands it back to software by clearing its ownership flag. At the end of the frame it waits for the transmitter's done strobe. It then writes the optional timestamp and the final status into the last descriptor, writing the ownership word last, and can raise a completion pulse. If it meets a descriptor still owned by software, it stops and flags the condition until software issues a poll demand.

Top module: `txdesc_walker`

## Requirements
- R1: After reset the walker is idle: it makes no memory request and holds buf_unavail and tx_irq low. The first poll_dmd pulse starts the first descriptor fetch at list_base.
- R2: A descriptor fetch is four word reads (mem_we = 0) at the descriptor address plus 0, 4, 8 and 12, in that order.
- R3: If word 0 has bit 31 (owned by DMA) clear, the walker makes no further reads of that descriptor. It sets buf_unavail, makes no request while suspended, and on the next poll_dmd clears buf_unavail and fetches the same descriptor address again.
- R4: A buffer of N bytes is read as ceil(N/4) word reads at consecutive 4-byte addresses. Buffer 1 (address in word 2, size in word 1 [12:0]) is read first, then buffer 2 (address in word 3, size in word 1 [28:16]). Each returned word appears on tx_data with tx_valid high in the cycle of its mem_ack.
- R5: A buffer whose size field is zero causes no memory read.
- R6: When word 0 bit 20 (chain) is set, word 3 is not read as a buffer and the next descriptor is fetched from the address held in word 3.
- R7: With bit 20 clear, the next descriptor is fetched at the current address plus 16. If word 0 bit 21 (end of list) is set, the next fetch goes to list_base instead.
- R8: For a descriptor without bit 29 (last segment), the walker writes word 0 back after the buffer reads, with bit 31 cleared and bits 30:0 unchanged, before it fetches the next descriptor.
- R9: frm_ctrl equals {w0[27], w0[26], w0[25], w0[23], w0[22]} of the descriptor that had bit 28 (first segment) set. Later descriptors of the same frame do not change it.
- R10: After the buffers of a bit-29 descriptor, tx_eof pulses for one cycle. The walker then waits for mac_done and writes word 0 of that descriptor as {0, w0[30:17], mac_stat}.
- R11: If frm_ctrl bit 2 (timestamp enable, first descriptor's bit 25) is set, mac_ts[31:0] is written to the last descriptor address + 8 and then mac_ts[63:32] to address + 12, both before word 0. Otherwise only word 0 is written.
- R12: tx_irq pulses for one cycle after the final word 0 write is acknowledged, only if that last descriptor has bit 30 set. Bit 30 in a descriptor without bit 29 has no effect.
- R13: Once raised, mem_req stays high with mem_addr, mem_we and mem_wdata stable until the cycle in which mem_ack is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| list_base | input | AW | Byte address of the descriptor list start, 16-byte aligned |
| poll_dmd | input | 1 | Poll demand strobe from software |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion of the pending access |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | A buffer word is on tx_data |
| tx_data | output | 32 | Buffer word toward the transmitter |
| tx_eof | output | 1 | All frame data has been delivered |
| frm_ctrl | output | 5 | Control bits of the current frame's first descriptor |
| mac_done | input | 1 | Transmitter finished the frame |
| mac_stat | input | 17 | Frame status for write-back |
| mac_ts | input | 64 | Captured frame timestamp |
| tx_irq | output | 1 | Transmit-complete pulse |
| buf_unavail | output | 1 | Suspended on a descriptor owned by software |

## Verification
The properties assume that the memory side raises mem_ack for a single cycle and only while a request is pending. They also assume well-formed lists: each frame opens with a first-segment mark and closes with a last-segment mark, all addresses are word aligned, descriptors sit on 16-byte boundaries, and mac_done arrives only after tx_eof. The bench's memory model keeps to these rules. It grants after zero to two pseudo-random wait cycles, and only while a request is up. Software-side edits of the memory are made only while the walker is suspended, and the transmitter model answers each tx_eof with a single done strobe.

// File: rtl/txdw_pkg.sv
package txdw_pkg;
  localparam int OWN_B = 31;
  localparam int IOC_B = 30;
  localparam int LSG_B = 29;
  localparam int FSG_B = 28;
  localparam int TSE_B = 25;
  localparam int EOL_B = 21;
  localparam int CHN_B = 20;
  localparam int CTLW  = 5;
  localparam int STW   = 17;
  localparam int SZW   = 13;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_BUF1, ST_BUF2, ST_DEND,
    ST_WBMID, ST_WAIT, ST_WBTL, ST_WBTH, ST_WBW0, ST_NEXT
  } wstate_t;
endpackage

// File: rtl/txdw_ptr.sv
module txdw_ptr #(
  parameter int AW     = 32,
  parameter int STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_base,
  input  logic          advance,
  input  logic          use_chain,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] link,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] cur_q, cur_n;

  always_comb begin
    cur_n = cur_q;
    if (load_base)
      cur_n = base;
    else if (advance) begin
      if (use_chain)
        cur_n = link;
      else if (wrap)
        cur_n = base;
      else
        cur_n = cur_q + AW'(STRIDE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_q <= '0;
    else if (load_base || advance)
      cur_q <= cur_n;
  end

  assign cur = cur_q;

  // R7: a ring step keeps the 16-byte phase of the pointer
  p_ring_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !use_chain && !wrap && !load_base) |=> (cur[3:0] == $past(cur[3:0])));
endmodule

// File: rtl/txdw_bufcnt.sv
module txdw_bufcnt #(
  parameter int AW  = 32,
  parameter int SZW = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  laddr,
  input  logic [SZW-1:0] lsize,
  input  logic           step,
  output logic [AW-1:0]  addr,
  output logic           empty
);
  localparam int WCW = SZW - 1;

  logic [AW-1:0]  addr_q, addr_n;
  logic [WCW-1:0] cnt_q, cnt_n;
  logic [SZW:0]   rnd;

  always_comb begin
    rnd    = {1'b0, lsize} + (SZW+1)'(3);
    addr_n = addr_q;
    cnt_n  = cnt_q;
    if (load) begin
      addr_n = laddr;
      cnt_n  = rnd[SZW:2];
    end else if (step) begin
      addr_n = addr_q + AW'(4);
      cnt_n  = cnt_q - WCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load || step) begin
      addr_q <= addr_n;
      cnt_q  <= cnt_n;
    end
  end

  assign addr  = addr_q;
  assign empty = (cnt_q == '0);

  // R5: no word is consumed from an exhausted or zero-sized buffer
  p_step_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !empty);
endmodule

// File: rtl/txdw_ctrl.sv
module txdw_ctrl
  import txdw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            poll_dmd,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            tx_valid,
  output logic            tx_eof,
  output logic [CTLW-1:0] frm_ctrl,
  input  logic            mac_done,
  input  logic [STW-1:0]  mac_stat,
  input  logic [63:0]     mac_ts,
  output logic            tx_irq,
  output logic            buf_unavail,
  input  logic [AW-1:0]   cur_addr,
  output logic            ptr_load_base,
  output logic            ptr_advance,
  output logic            ptr_chain,
  output logic            ptr_wrap,
  output logic [AW-1:0]   ptr_link,
  input  logic [AW-1:0]   buf_addr,
  input  logic            buf_empty,
  output logic            buf_load,
  output logic [AW-1:0]   buf_laddr,
  output logic [SZW-1:0]  buf_lsize,
  output logic            buf_step
);
  wstate_t         st_q, st_n;
  logic [1:0]      widx_q, widx_n;
  logic [30:0]     w0_q, w0_n;
  logic [SZW-1:0]  sz1_q, sz1_n, sz2_q, sz2_n;
  logic [AW-1:0]   w2_q, w2_n, w3_q, w3_n;
  logic [CTLW-1:0] ctl_q, ctl_n;
  logic [STW-1:0]  stat_q, stat_n;
  logic [63:0]     ts_q, ts_n;
  logic            irq_q, irq_n;
  logic            unav_q, unav_n;
  logic            started_q, started_n;

  always_comb begin
    st_n          = st_q;
    widx_n        = widx_q;
    w0_n          = w0_q;
    sz1_n         = sz1_q;
    sz2_n         = sz2_q;
    w2_n          = w2_q;
    w3_n          = w3_q;
    ctl_n         = ctl_q;
    stat_n        = stat_q;
    ts_n          = ts_q;
    irq_n         = 1'b0;
    unav_n        = unav_q;
    started_n     = started_q;
    mem_req       = 1'b0;
    mem_we        = 1'b0;
    mem_addr      = cur_addr;
    mem_wdata     = '0;
    tx_valid      = 1'b0;
    tx_eof        = 1'b0;
    ptr_load_base = 1'b0;
    ptr_advance   = 1'b0;
    buf_load      = 1'b0;
    buf_laddr     = w2_q;
    buf_lsize     = sz1_q;
    buf_step      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (poll_dmd) begin
          ptr_load_base = !started_q;
          started_n     = 1'b1;
          unav_n        = 1'b0;
          widx_n        = 2'd0;
          st_n          = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_addr + {{(AW-4){1'b0}}, widx_q, 2'b00};
        if (mem_ack) begin
          widx_n = widx_q + 2'd1;
          case (widx_q)
            2'd0: begin
              w0_n = mem_rdata[30:0];
              if (!mem_rdata[OWN_B]) begin
                unav_n = 1'b1;
                st_n   = ST_IDLE;
              end else if (mem_rdata[FSG_B]) begin
                ctl_n = {mem_rdata[27], mem_rdata[26], mem_rdata[TSE_B],
                         mem_rdata[23], mem_rdata[22]};
              end
            end
            2'd1: begin
              sz1_n = mem_rdata[SZW-1:0];
              sz2_n = mem_rdata[16 +: SZW];
            end
            2'd2: w2_n = mem_rdata[AW-1:0];
            default: begin
              w3_n      = mem_rdata[AW-1:0];
              buf_load  = 1'b1;
              buf_laddr = w2_q;
              buf_lsize = sz1_q;
              st_n      = ST_BUF1;
            end
          endcase
        end
      end
      ST_BUF1, ST_BUF2: begin
        if (buf_empty) begin
          if (st_q == ST_BUF1 && !w0_q[CHN_B]) begin
            buf_load  = 1'b1;
            buf_laddr = w3_q;
            buf_lsize = sz2_q;
            st_n      = ST_BUF2;
          end else begin
            st_n = ST_DEND;
          end
        end else begin
          mem_req  = 1'b1;
          mem_addr = buf_addr;
          if (mem_ack) begin
            tx_valid = 1'b1;
            buf_step = 1'b1;
          end
        end
      end
      ST_DEND: begin
        if (w0_q[LSG_B]) begin
          tx_eof = 1'b1;
          st_n   = ST_WAIT;
        end else begin
          st_n = ST_WBMID;
        end
      end
      ST_WBMID: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {1'b0, w0_q};
        if (mem_ack) st_n = ST_NEXT;
      end
      ST_WAIT: begin
        if (mac_done) begin
          stat_n = mac_stat;
          ts_n   = mac_ts;
          st_n   = ctl_q[2] ? ST_WBTL : ST_WBW0;
        end
      end
      ST_WBTL: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_addr + AW'(8);
        mem_wdata = ts_q[31:0];
        if (mem_ack) st_n = ST_WBTH;
      end
      ST_WBTH: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_addr + AW'(12);
        mem_wdata = ts_q[63:32];
        if (mem_ack) st_n = ST_WBW0;
      end
      ST_WBW0: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {1'b0, w0_q[30:STW], stat_q};
        if (mem_ack) begin
          irq_n = w0_q[IOC_B];
          st_n  = ST_NEXT;
        end
      end
      ST_NEXT: begin
        ptr_advance = 1'b1;
        widx_n      = 2'd0;
        st_n        = ST_FETCH;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      widx_q    <= '0;
      w0_q      <= '0;
      sz1_q     <= '0;
      sz2_q     <= '0;
      w2_q      <= '0;
      w3_q      <= '0;
      ctl_q     <= '0;
      stat_q    <= '0;
      ts_q      <= '0;
      irq_q     <= 1'b0;
      unav_q    <= 1'b0;
      started_q <= 1'b0;
    end else begin
      st_q      <= st_n;
      widx_q    <= widx_n;
      w0_q      <= w0_n;
      sz1_q     <= sz1_n;
      sz2_q     <= sz2_n;
      w2_q      <= w2_n;
      w3_q      <= w3_n;
      ctl_q     <= ctl_n;
      stat_q    <= stat_n;
      ts_q      <= ts_n;
      irq_q     <= irq_n;
      unav_q    <= unav_n;
      started_q <= started_n;
    end
  end

  assign frm_ctrl    = ctl_q;
  assign tx_irq      = irq_q;
  assign buf_unavail = unav_q;
  assign ptr_chain   = w0_q[CHN_B];
  assign ptr_wrap    = w0_q[EOL_B];
  assign ptr_link    = w3_q;

  // R13: a pending access is held unchanged until acknowledged
  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  // R3: nothing is requested while suspended on a software-owned entry
  p_quiet_suspend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unavail |-> !mem_req);
  // R12: the completion pulse follows an acknowledged write
  p_irq_after_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(mem_req && mem_we && mem_ack));
  // R4: forwarded data is always an acknowledged read
  p_data_is_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (mem_req && !mem_we && mem_ack));
  // R10: end-of-frame is a single-cycle pulse
  p_eof_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eof |=> !tx_eof);
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
  import txdw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int STRIDE = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   list_base,
  input  logic            poll_dmd,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            tx_valid,
  output logic [31:0]     tx_data,
  output logic            tx_eof,
  output logic [CTLW-1:0] frm_ctrl,
  input  logic            mac_done,
  input  logic [STW-1:0]  mac_stat,
  input  logic [63:0]     mac_ts,
  output logic            tx_irq,
  output logic            buf_unavail
);
  logic [1:0]     rsync_q;
  logic           rst_l;
  logic [AW-1:0]  cur_addr, ptr_link, buf_addr, buf_laddr;
  logic           ptr_load_base, ptr_advance, ptr_chain, ptr_wrap;
  logic           buf_empty, buf_load, buf_step;
  logic [SZW-1:0] buf_lsize;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rsync_q <= 2'b00;
    else
      rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_l = rsync_q[1];

  txdw_ptr #(.AW(AW), .STRIDE(STRIDE)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_l),
    .load_base (ptr_load_base),
    .advance   (ptr_advance),
    .use_chain (ptr_chain),
    .wrap      (ptr_wrap),
    .base      (list_base),
    .link      (ptr_link),
    .cur       (cur_addr)
  );

  txdw_bufcnt #(.AW(AW), .SZW(SZW)) u_buf (
    .clk   (clk),
    .rst_n (rst_l),
    .load  (buf_load),
    .laddr (buf_laddr),
    .lsize (buf_lsize),
    .step  (buf_step),
    .addr  (buf_addr),
    .empty (buf_empty)
  );

  txdw_ctrl #(.AW(AW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_l),
    .poll_dmd      (poll_dmd),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .tx_valid      (tx_valid),
    .tx_eof        (tx_eof),
    .frm_ctrl      (frm_ctrl),
    .mac_done      (mac_done),
    .mac_stat      (mac_stat),
    .mac_ts        (mac_ts),
    .tx_irq        (tx_irq),
    .buf_unavail   (buf_unavail),
    .cur_addr      (cur_addr),
    .ptr_load_base (ptr_load_base),
    .ptr_advance   (ptr_advance),
    .ptr_chain     (ptr_chain),
    .ptr_wrap      (ptr_wrap),
    .ptr_link      (ptr_link),
    .buf_addr      (buf_addr),
    .buf_empty     (buf_empty),
    .buf_load      (buf_load),
    .buf_laddr     (buf_laddr),
    .buf_lsize     (buf_lsize),
    .buf_step      (buf_step)
  );

  assign tx_data = mem_rdata;
endmodule

// File: tb/txdesc_walker_bench.sv
`timescale 1ns/1ps
module txdesc_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] list_base;
  logic        poll_dmd;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_eof, tx_irq, buf_unavail;
  logic [31:0] tx_data;
  logic [4:0]  frm_ctrl;
  logic        mac_done;
  logic [16:0] mac_stat;
  logic [63:0] mac_ts;

  always #2 clk = ~clk;

  txdesc_walker u_txdesc_walker (
    .clk(clk), .rst_n(rst_n), .list_base(list_base), .poll_dmd(poll_dmd),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_eof(tx_eof), .frm_ctrl(frm_ctrl), .mac_done(mac_done), .mac_stat(mac_stat),
    .mac_ts(mac_ts), .tx_irq(tx_irq), .buf_unavail(buf_unavail)
  );

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  logic [31:0] mem [0:255];
  logic        e_we [$];
  logic [31:0] e_addr [$];
  logic [31:0] e_data [$];
  string       e_tag [$];
  logic [31:0] t_data [$];
  logic [4:0]  exp_ctrl;
  logic [16:0] nxt_stat;
  logic [63:0] nxt_ts;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_acc(input logic we, input logic [31:0] a, input logic [31:0] d, input string tag);
    e_we.push_back(we);
    e_addr.push_back(a);
    e_data.push_back(d);
    e_tag.push_back(tag);
  endtask

  task automatic push_fetch(input logic [31:0] a, input string tag);
    for (int k = 0; k < 4; k++) push_acc(1'b0, a + 32'(4*k), 32'h0, tag);
  endtask

  task automatic push_buf(input logic [31:0] a, input int bytes, input string tag);
    for (int k = 0; k < (bytes + 3) / 4; k++) begin
      push_acc(1'b0, a + 32'(4*k), 32'h0, tag);
      t_data.push_back(mem[(a[9:2] + 8'(k))]);
    end
  endtask

  task automatic poll;
    @(negedge clk); poll_dmd = 1'b1;
    @(negedge clk); poll_dmd = 1'b0;
  endtask

  task automatic wait_idle;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (buf_unavail && e_we.size() == 0) break;
    end
    repeat (10) @(negedge clk);
  endtask

  // memory model and scoreboard monitor
  bit       pending = 1'b0;
  int       wait_left = 0;
  logic [31:0] pend_addr;
  logic [7:0]  lfsr = 8'h5A;
  initial begin
    mem_ack = 1'b0;
    mem_rdata = 32'h0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (tx_irq) irq_cnt++;
      if (tx_eof) chk(frm_ctrl == exp_ctrl, "R9 frame control", 64'(frm_ctrl), 64'(exp_ctrl));
      if (rst_n && mem_req) begin
        if (!pending) begin
          pending = 1'b1;
          pend_addr = mem_addr;
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          wait_left = int'(lfsr % 8'd3);
        end
        if (wait_left != 0) wait_left--;
        else begin
          pending = 1'b0;
          chk(mem_addr == pend_addr, "R13 held address", 64'(mem_addr), 64'(pend_addr));
          if (e_we.size() == 0) chk(1'b0, "R2 unexpected access", 64'(mem_addr), 64'hFFFFFFFF);
          else begin
            logic        xw;
            logic [31:0] xa, xd;
            string       xt;
            xw = e_we.pop_front(); xa = e_addr.pop_front();
            xd = e_data.pop_front(); xt = e_tag.pop_front();
            chk(mem_we == xw && mem_addr == xa, xt, {31'h0, mem_we, mem_addr}, {31'h0, xw, xa});
            if (xw) chk(mem_wdata == xd, xt, 64'(mem_wdata), 64'(xd));
          end
          if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
          else mem_rdata = mem[mem_addr[9:2]];
          mem_ack = 1'b1;
          #1;
          if (tx_valid) begin
            if (t_data.size() == 0) chk(1'b0, "R4 extra data", 64'(tx_data), 64'h0);
            else begin
              logic [31:0] xe;
              xe = t_data.pop_front();
              chk(tx_data == xe, "R4 buffer data", 64'(tx_data), 64'(xe));
            end
          end
        end
      end
    end
  end

  // transmitter model
  initial begin
    mac_done = 1'b0;
    mac_stat = '0;
    mac_ts = '0;
    forever begin
      @(negedge clk);
      if (tx_eof) begin
        repeat (3) @(negedge clk);
        mac_stat = nxt_stat;
        mac_ts = nxt_ts;
        mac_done = 1'b1;
        @(negedge clk);
        mac_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [31:0] wa, wb1, wb2;
  initial begin
    rst_n = 1'b0;
    poll_dmd = 1'b0;
    list_base = 32'h100;
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 + 32'(i * 7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_req == 1'b0, "R1 no request", 64'(mem_req), 64'h0);
    chk(buf_unavail == 1'b0, "R1 unavail low", 64'(buf_unavail), 64'h0);
    chk(tx_irq == 1'b0, "R1 irq low", 64'(tx_irq), 64'h0);
    repeat (10) @(negedge clk);
    chk(mem_req == 1'b0, "R1 idle until poll", 64'(mem_req), 64'h0);

    // frame A: one descriptor, ring mode, timestamp, interrupt
    wa = 32'hF2000000;
    mem[8'h40] = wa;
    mem[8'h41] = 32'h0005_0008;
    mem[8'h42] = 32'h200;
    mem[8'h43] = 32'h240;
    mem[8'h44] = 32'h0;
    exp_ctrl = 5'b00100;
    nxt_stat = 17'h1ABCD;
    nxt_ts = 64'h1122334455667788;
    push_acc(1'b0, 32'h100, 32'h0, "R1 first fetch at base");
    push_acc(1'b0, 32'h104, 32'h0, "R2 word order");
    push_acc(1'b0, 32'h108, 32'h0, "R2 word order");
    push_acc(1'b0, 32'h10C, 32'h0, "R2 word order");
    push_buf(32'h200, 8, "R4 buffer 1");
    push_buf(32'h240, 5, "R4 buffer 2");
    push_acc(1'b1, 32'h108, 32'h55667788, "R11 timestamp low");
    push_acc(1'b1, 32'h10C, 32'h11223344, "R11 timestamp high");
    push_acc(1'b1, 32'h100, (wa & 32'h7FFE0000) | 32'h1ABCD, "R10 final status");
    push_acc(1'b0, 32'h110, 32'h0, "R7 ring stride");
    poll();
    wait_idle();
    chk(buf_unavail == 1'b1, "R3 suspended", 64'(buf_unavail), 64'h1);
    chk(irq_cnt == 1, "R12 irq after frame A", 64'(irq_cnt), 64'h1);
    chk(e_we.size() == 0, "R3 no read past word 0", 64'(e_we.size()), 64'h0);

    // frame B: chained first descriptor, ring-mode last with wrap
    wb1 = 32'hD8D00000;
    wb2 = 32'hA6200000;
    mem[8'h44] = wb1;
    mem[8'h45] = 32'h0007_0004;
    mem[8'h46] = 32'h280;
    mem[8'h47] = 32'h180;
    mem[8'h60] = wb2;
    mem[8'h61] = 32'h0003_0000;
    mem[8'h62] = 32'h2C0;
    mem[8'h63] = 32'h2A0;
    exp_ctrl = 5'b10011;
    nxt_stat = 17'h0F0F1;
    nxt_ts = 64'hDEADBEEF_CAFEF00D;
    push_fetch(32'h110, "R3 refetch same entry");
    push_buf(32'h280, 4, "R6 chain: one buffer only");
    push_acc(1'b1, 32'h110, wb1 & 32'h7FFFFFFF, "R8 hand back middle entry");
    push_fetch(32'h180, "R6 next from word 3");
    push_buf(32'h2A0, 3, "R5 zero-size buffer skipped");
    push_acc(1'b1, 32'h180, (wb2 & 32'h7FFE0000) | 32'h0F0F1, "R11 no timestamp, R10 status");
    push_acc(1'b0, 32'h100, 32'h0, "R7 wrap to base");
    poll();
    chk(buf_unavail == 1'b0, "R3 poll clears flag", 64'(buf_unavail), 64'h0);
    wait_idle();
    chk(buf_unavail == 1'b1, "R3 suspended on returned entry", 64'(buf_unavail), 64'h1);
    chk(irq_cnt == 1, "R12 no irq for frame B", 64'(irq_cnt), 64'h1);
    chk(e_we.size() == 0, "R2 all accesses seen", 64'(e_we.size()), 64'h0);
    chk(t_data.size() == 0, "R4 all data seen", 64'(t_data.size()), 64'h0);
    chk(mem[8'h44][31] == 1'b0, "R8 ownership cleared", 64'(mem[8'h44]), 64'(wb1 & 32'h7FFFFFFF));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule